// File: doc/BRIEF.md
# Third-Order Bitstream Decimator

This block turns the single-bit pulse-density stream of an external sigma-delta modulator into 16-bit unsigned samples. The block runs on the modulator's own clock. On every rising edge it registers the data bit, which the modulator drove after the edge before. The bits pass through a cascade of three integrators. Once every 256 clocks the integrator sum is handed to three first-difference stages. That sum is a sinc-cubed response with a DC gain of 2^24. It is reduced to 16 bits by discarding its eight lowest bits, and the one value that would overflow is clamped.

The result is offset-binary: code 0 stands for a stream of all zeros, mid-scale 32768 for equal numbers of ones and zeros, and the top code for a stream of all ones. Each new sample is announced by a one-cycle strobe, and the sample stays on the output until the next strobe. While the difference stages fill after reset, the first two samples are held back.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the output code is 0 and the strobe is low.
- R2: The strobe is high for exactly one clock cycle. After the first strobe, strobes follow one another every 256 rising clock edges.
- R3: The first two decimated samples after reset are suppressed. Counting the rising edge after reset release as edge 1, the first strobe is visible after rising edge 769.
- R4: The data bit is captured on the rising clock edge that follows the modulator's update. For a periodic stream whose period divides 256, the steady-state code equals the ones fraction times 65536. This gives: 0% gives 0, 18.75% gives 12288, 25% gives 16384, 50% gives 32768, 75% gives 49152, 81.25% gives 53248.
- R5: A continuous stream of ones gives the code 65535, not a wrapped value.
- R6: Between strobes the output code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mod_clk | input | 1 | Modulator clock; every register in the block uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator data bit, updated shortly after each rising clock edge |
| code_o | output | 16 | Decimated sample, offset-binary |
| code_vld_o | output | 1 | One-cycle strobe marking a new sample on code_o |

## Verification
An error in an integrator or a difference register corrupts the very next sample. It appears as a code away from the density-derived value one strobe (256 edges) after the fault. Sums and delay values carry across samples, so the wrong code then persists for two further samples before a clean window washes it out. A slip in the decimation count or in the warm-up count shows at once in when the strobes appear: the first strobe comes at the wrong edge, or the spacing is not 256. A fault in the clamp shows only on the all-ones stream, as code 0 instead of 65535.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
    localparam int unsigned DEF_ORDER    = 3;
    localparam int unsigned DEF_DEC_LOG2 = 8;
    localparam int unsigned DEF_OUT_W    = 16;
    localparam int unsigned DEF_WARMUP   = 2;

    // accumulator width needed for a CIC of given order and decimation
    function automatic int unsigned acc_width(input int unsigned order,
                                              input int unsigned dec_log2);
        return order * dec_log2 + 1;
    endfunction
endpackage

// File: rtl/sinc3_ctrl.sv
`timescale 1ns/1ps
module sinc3_ctrl #(
    parameter int unsigned DEC_LOG2 = 8
) (
    input  logic mod_clk,
    input  logic rst,
    output logic dec_stb
);
    typedef struct packed {
        logic [DEC_LOG2-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        dec_stb  = &st_q.cnt;
    end

    always_ff @(posedge mod_clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/sinc3_integ.sv
`timescale 1ns/1ps
module sinc3_integ #(
    parameter int unsigned ORDER = 3,
    parameter int unsigned ACC_W = 25
) (
    input  logic             mod_clk,
    input  logic             rst,
    input  logic             bit_i,
    output logic [ACC_W-1:0] sum_o
);
    typedef struct packed {
        logic                        smp;
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.smp    = bit_i;
        st_d.acc[0] = st_q.acc[0] + ACC_W'(st_q.smp);
        for (int k = 1; k < ORDER; k++) begin
            st_d.acc[k] = st_q.acc[k] + st_q.acc[k-1];
        end
    end

    always_ff @(posedge mod_clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sum_o = st_q.acc[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
`timescale 1ns/1ps
module sinc3_comb #(
    parameter int unsigned ORDER = 3,
    parameter int unsigned ACC_W = 25
) (
    input  logic             mod_clk,
    input  logic             rst,
    input  logic             dec_stb,
    input  logic [ACC_W-1:0] sum_i,
    output logic [ACC_W-1:0] diff_o,
    output logic             diff_vld
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]            res;
        logic                        vld;
    } comb_t;

    comb_t st_d, st_q;
    logic [ORDER:0][ACC_W-1:0] chain;

    assign chain[0] = sum_i;
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign chain[g+1] = chain[g] - st_q.dly[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = dec_stb;
        if (dec_stb) begin
            st_d.res = chain[ORDER];
            for (int k = 0; k < ORDER; k++) begin
                st_d.dly[k] = chain[k];
            end
        end
    end

    always_ff @(posedge mod_clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign diff_o   = st_q.res;
    assign diff_vld = st_q.vld;
endmodule

// File: rtl/sinc3_out.sv
`timescale 1ns/1ps
module sinc3_out #(
    parameter int unsigned ACC_W  = 25,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned WARMUP = 2
) (
    input  logic             mod_clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] diff_i,
    input  logic             diff_vld,
    output logic [OUT_W-1:0] code_o,
    output logic             code_vld_o
);
    localparam int unsigned SHIFT = ACC_W - 1 - OUT_W;
    localparam int unsigned SKW   = $clog2(WARMUP + 1);

    typedef struct packed {
        logic [OUT_W-1:0] code;
        logic             vld;
        logic [SKW-1:0]   skip;
    } out_t;

    out_t st_d, st_q;
    logic [OUT_W:0]   scaled;
    logic [OUT_W-1:0] clamped;

    assign scaled  = diff_i[ACC_W-1:SHIFT];
    assign clamped = scaled[OUT_W] ? '1 : scaled[OUT_W-1:0];

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (diff_vld) begin
            if (st_q.skip == SKW'(WARMUP)) begin
                st_d.code = clamped;
                st_d.vld  = 1'b1;
            end else begin
                st_d.skip = st_q.skip + 1'b1;
            end
        end
    end

    always_ff @(posedge mod_clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code_o     = st_q.code;
    assign code_vld_o = st_q.vld;
endmodule

// File: rtl/sinc3_decim.sv
`timescale 1ns/1ps
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int unsigned ORDER    = DEF_ORDER,
    parameter int unsigned DEC_LOG2 = DEF_DEC_LOG2,
    parameter int unsigned OUT_W    = DEF_OUT_W,
    parameter int unsigned WARMUP   = DEF_WARMUP
) (
    input  logic             mod_clk,
    input  logic             rst,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] code_o,
    output logic             code_vld_o
);
    localparam int unsigned ACC_W = acc_width(ORDER, DEC_LOG2);

    logic             dec_stb;
    logic [ACC_W-1:0] int_sum;
    logic [ACC_W-1:0] comb_res;
    logic             comb_vld;

    sinc3_ctrl #(.DEC_LOG2(DEC_LOG2)) u_ctrl (
        .mod_clk (mod_clk),
        .rst     (rst),
        .dec_stb (dec_stb)
    );

    sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .mod_clk (mod_clk),
        .rst     (rst),
        .bit_i   (mod_bit),
        .sum_o   (int_sum)
    );

    sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .mod_clk  (mod_clk),
        .rst      (rst),
        .dec_stb  (dec_stb),
        .sum_i    (int_sum),
        .diff_o   (comb_res),
        .diff_vld (comb_vld)
    );

    sinc3_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .WARMUP(WARMUP)) u_out (
        .mod_clk    (mod_clk),
        .rst        (rst),
        .diff_i     (comb_res),
        .diff_vld   (comb_vld),
        .code_o     (code_o),
        .code_vld_o (code_vld_o)
    );
endmodule

// File: rtl/sinc3_decim_chk.sv
`timescale 1ns/1ps
module sinc3_decim_chk #(
    parameter int unsigned DEC    = 256,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned WARMUP = 2
) (
    input logic             mod_clk,
    input logic             rst,
    input logic [OUT_W-1:0] code_o,
    input logic             code_vld_o
);
    localparam int unsigned FIRST = (WARMUP + 1) * DEC;

    logic [31:0] gap_q;
    logic        seen_q;
    logic [31:0] age_q;

    always_ff @(posedge mod_clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            age_q  <= '0;
        end else begin
            gap_q  <= code_vld_o ? '0 : (gap_q + 1);
            seen_q <= seen_q | code_vld_o;
            if (age_q < FIRST) age_q <= age_q + 1;
        end
    end

    p_reset_state_r1: assert property (@(posedge mod_clk) disable iff (rst)
        $past(rst) |-> (code_o == '0 && !code_vld_o));

    p_single_pulse_r2: assert property (@(posedge mod_clk) disable iff (rst)
        code_vld_o |=> !code_vld_o);

    p_pulse_spacing_r2: assert property (@(posedge mod_clk) disable iff (rst)
        (code_vld_o && seen_q) |-> (gap_q == DEC - 1));

    p_warmup_r3: assert property (@(posedge mod_clk) disable iff (rst)
        code_vld_o |-> (age_q >= FIRST));

    p_code_hold_r6: assert property (@(posedge mod_clk) disable iff (rst)
        !code_vld_o |-> $stable(code_o));
endmodule

bind sinc3_decim sinc3_decim_chk #(
    .DEC    (1 << DEC_LOG2),
    .OUT_W  (OUT_W),
    .WARMUP (WARMUP)
) u_chk (
    .mod_clk    (mod_clk),
    .rst        (rst),
    .code_o     (code_o),
    .code_vld_o (code_vld_o)
);

// File: tb/test_sinc3_decim.sv
`timescale 1ns/1ps
module test_sinc3_decim;
    logic        mod_clk = 1'b0;
    logic        rst     = 1'b1;
    logic        mod_bit = 1'b0;
    logic [15:0] code_o;
    logic        code_vld_o;

    int checks = 0;
    int errors = 0;
    int pat_period = 2;
    int pat_ones   = 0;
    int phase      = 0;

    sinc3_decim i_sinc3_decim (
        .mod_clk    (mod_clk),
        .rst        (rst),
        .mod_bit    (mod_bit),
        .code_o     (code_o),
        .code_vld_o (code_vld_o)
    );

    always #4 mod_clk = ~mod_clk;

    // modulator model: new bit a short access time after each rising edge
    initial begin
        forever begin
            @(posedge mod_clk);
            #2;
            mod_bit = ((phase % pat_period) < pat_ones);
            phase   = (phase + 1) % 256;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge mod_clk); while (!code_vld_o);
    endtask

    task automatic test_reset_and_timing();
        int edges;
        rst = 1'b1;
        repeat (5) @(negedge mod_clk);
        check(code_o == 16'd0, "R1 code in reset", code_o, 0);
        check(code_vld_o == 1'b0, "R1 strobe in reset", code_vld_o, 0);
        rst = 1'b0;
        @(negedge mod_clk);
        check(code_o == 16'd0 && !code_vld_o, "R1 first cycle after reset", code_o, 0);
        edges = 1;
        while (!code_vld_o && edges < 2000) begin
            @(negedge mod_clk);
            edges++;
        end
        check(edges == 769, "R3 first strobe edge", edges, 769);
        @(negedge mod_clk);
        check(code_vld_o == 1'b0, "R2 strobe width", code_vld_o, 0);
        edges = 1;
        while (!code_vld_o && edges < 2000) begin
            @(negedge mod_clk);
            edges++;
        end
        check(edges == 256, "R2 strobe spacing", edges, 256);
    endtask

    task automatic test_density(input int period, input int ones, input int exp, input string req);
        logic [15:0] got;
        pat_period = period;
        pat_ones   = ones;
        repeat (4) wait_strobe();
        wait_strobe();
        got = code_o;
        check(got == 16'(exp), req, got, exp);
        repeat (100) @(negedge mod_clk);
        check(code_o == got && !code_vld_o, "R6 code held between strobes", code_o, got);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset_and_timing();
        test_density(2,  1,  32768, "R4 density 50%");
        test_density(16, 3,  12288, "R4 density 18.75%");
        test_density(16, 13, 53248, "R4 density 81.25%");
        test_density(2,  0,  0,     "R4 density 0%");
        test_density(4,  1,  16384, "R4 density 25%");
        test_density(4,  3,  49152, "R4 density 75%");
        test_density(2,  2,  65535, "R5 all ones clamp");
        test_density(16, 3,  12288, "R4 recovery after clamp");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule